// File: doc/BRIEF.md
# Relative Branch Cycle Sequencer

This block runs the bus cycles of a conditional relative branch on an 8-bit processor with a 16-bit program counter. A request carries the address of the branch opcode and the already evaluated branch condition. From then on the block issues one read per clock. It fetches the opcode and then the signed offset byte. Next it reads the fall-through address, which is the opcode address plus two. A taken branch adds the offset to the low address byte only. The block then reads from that partly formed address. If the low-byte addition crossed a page, the block repairs the high byte and spends one more cycle. The last read of every sequence is the fetch of the next opcode, at the final program counter.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no sequence is running and no result is waiting. The result side is also a valid/ready stream. `res_valid` stays high, and `res_pc` and `res_cycles` stay unchanged, until an edge where `res_ready` is high. While a result is held, the block issues no reads and takes no request. After the result is accepted, a new request can be taken from the following cycle. The offset arrives on `rd_data` in the same cycle as its read address.

Top module: `bnc_branch_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `rd_en` is 0.
- R2: The first read after a request is accepted is at the opcode address P. The second is at P+1, and the byte on `rd_data` in that cycle is taken as the offset.
- R3: A not-taken branch reads P+2 in its third cycle and ends there: `res_pc` = P+2, `res_cycles` = 2, three reads in total.
- R4: A taken branch whose target lies in the same 256-byte page as P+2 makes its fourth read at the target and ends: `res_cycles` = 3, and `rd_wrong_page` stays 0.
- R5: A taken branch with a non-negative offset that carries out of the low byte makes its fourth read at {high byte of P+2, low byte of the target}, with `rd_wrong_page` = 1. Its fifth read is at the target, whose high byte is one more. `res_cycles` = 4.
- R6: A taken branch with a negative offset that borrows out of the low byte makes the same wrong-page fourth read. Its fifth read is at the target, whose high byte is one less. `res_cycles` = 4.
- R7: The offset is a two's-complement byte (-128..+127) added to P+2. This holds at both extremes, with and without a page change.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_pc` and `res_cycles` hold, `rd_en` is 0 and `req_ready` is 0.
- R9: `req_valid` has no effect while a sequence runs or a result waits. The reads and the result come from the accepted request alone.
- R10: Addresses wrap modulo 2^16: both the P+1/P+2 increments and the page fix.
- R11: `rd_en` is high for exactly `res_cycles`+1 consecutive cycles per branch, and `res_cycles` is always 2, 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Branch request present |
| req_ready | output | 1 | Block idle with no pending result |
| req_pc | input | 16 | Address of the branch opcode |
| req_taken | input | 1 | Branch condition result |
| rd_en | output | 1 | A bus read is issued this cycle |
| rd_addr | output | 16 | Read address |
| rd_wrong_page | output | 1 | This read uses the uncorrected high byte |
| rd_data | input | 8 | Read data, valid in the same cycle |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_pc | output | 16 | Final program counter (next opcode address) |
| res_cycles | output | 3 | Cycles the branch used: 2, 3 or 4 |

## Verification
A wrong latched offset or carry decision shows at the ports within one cycle of the third read. It appears either as a fourth read at the wrong low byte or as a wrong-page flag where none belongs. A wrong state step shows at once as a read address that does not follow the expected order. It also shows as a read count, and therefore a `res_cycles`, one off from the page-crossing rule. The scenarios place offsets so the low-byte sum lands just past or just short of a page edge in both directions. They also include the 0xFFFF/0x0000 wrap, so an inverted fix direction or a dropped carry changes the fifth read address.

// File: rtl/bnc_pkg.sv
package bnc_pkg;
  localparam int CYC_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_OFS,
    ST_BASE,
    ST_PROBE,
    ST_FIX
  } seq_state_e;

  localparam logic [CYC_W-1:0] CYC_FALL  = CYC_W'(2);
  localparam logic [CYC_W-1:0] CYC_NEAR  = CYC_W'(3);
  localparam logic [CYC_W-1:0] CYC_FAR   = CYC_W'(4);
endpackage

// File: rtl/bnc_lo_add.sv
module bnc_lo_add #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lo_byte,
  input  logic [DATA_W-1:0] off_byte,
  output logic [DATA_W-1:0] lo_sum,
  output logic              lo_cross,
  output logic              lo_fwd
);
  logic [DATA_W:0] wide_sum;
  logic            neg;

  always_comb begin
    wide_sum = {1'b0, lo_byte} + {1'b0, off_byte};
    neg      = off_byte[DATA_W-1];
    lo_sum   = wide_sum[DATA_W-1:0];
    // a carry with a positive offset or no carry with a negative one leaves the page
    lo_cross = wide_sum[DATA_W] ^ neg;
    lo_fwd   = ~neg;
  end
endmodule

// File: rtl/bnc_page_fix.sv
module bnc_page_fix #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page_in,
  input  logic              page_up,
  output logic [PAGE_W-1:0] page_out
);
  localparam logic [PAGE_W-1:0] STEP = PAGE_W'(1);

  logic [PAGE_W-1:0] inc_v;
  logic [PAGE_W-1:0] dec_v;

  always_comb begin
    inc_v    = page_in + STEP;
    dec_v    = page_in - STEP;
    page_out = page_up ? inc_v : dec_v;
  end
endmodule

// File: rtl/bnc_result_hold.sv
module bnc_result_hold #(
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_pc,
  input  logic [CYC_W-1:0]  ld_cycles,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_pc,
  output logic [CYC_W-1:0]  res_cycles
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_pc     <= '0;
      res_cycles <= '0;
    end else if (ld_en) begin
      res_valid  <= 1'b1;
      res_pc     <= ld_pc;
      res_cycles <= ld_cycles;
    end else if (res_valid && res_ready) begin
      res_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bnc_seq_fsm.sv
module bnc_seq_fsm
  import bnc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_taken,
  input  logic              res_busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_wrong_page,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] lo_byte,
  output logic [DATA_W-1:0] off_byte,
  input  logic [DATA_W-1:0] lo_sum,
  input  logic              lo_cross,
  input  logic              lo_fwd,
  output logic [PAGE_W-1:0] page_in,
  output logic              page_up,
  input  logic [PAGE_W-1:0] page_out,
  output logic              ld_en,
  output logic [ADDR_W-1:0] ld_pc,
  output logic [CYC_W-1:0]  ld_cycles
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] off_q;
  logic              taken_q;
  logic              cross_q;
  logic              up_q;

  assign req_ready     = (state_q == ST_IDLE) && !res_busy;
  assign rd_en         = (state_q != ST_IDLE);
  assign rd_addr       = rd_en ? pc_q : '0;
  assign rd_wrong_page = (state_q == ST_PROBE) && cross_q;
  assign lo_byte       = pc_q[DATA_W-1:0];
  assign off_byte      = off_q;
  assign page_in       = pc_q[ADDR_W-1:DATA_W];
  assign page_up       = up_q;

  always_comb begin
    ld_en     = 1'b0;
    ld_pc     = pc_q;
    ld_cycles = CYC_FALL;
    unique case (state_q)
      ST_BASE:  if (!taken_q) ld_en = 1'b1;
      ST_PROBE: if (!cross_q) begin
                  ld_en     = 1'b1;
                  ld_cycles = CYC_NEAR;
                end
      ST_FIX:   begin
                  ld_en     = 1'b1;
                  ld_cycles = CYC_FAR;
                end
      default:  ld_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      off_q   <= '0;
      taken_q <= 1'b0;
      cross_q <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            pc_q    <= req_pc;
            taken_q <= req_taken;
            cross_q <= 1'b0;
            state_q <= ST_OPC;
          end
        end
        ST_OPC: begin
          pc_q    <= pc_q + ONE;
          state_q <= ST_OFS;
        end
        ST_OFS: begin
          off_q   <= rd_data;
          pc_q    <= pc_q + ONE;
          state_q <= ST_BASE;
        end
        ST_BASE: begin
          if (taken_q) begin
            pc_q    <= {pc_q[ADDR_W-1:DATA_W], lo_sum};
            cross_q <= lo_cross;
            up_q    <= lo_fwd;
            state_q <= ST_PROBE;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_PROBE: begin
          if (cross_q) begin
            pc_q    <= {page_out, pc_q[DATA_W-1:0]};
            state_q <= ST_FIX;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_FIX: begin
          cross_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bnc_branch_seq.sv
module bnc_branch_seq
  import bnc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_taken,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_wrong_page,
  input  logic [DATA_W-1:0] rd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_pc,
  output logic [CYC_W-1:0]  res_cycles
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] lo_byte;
  logic [DATA_W-1:0] off_byte;
  logic [DATA_W-1:0] lo_sum;
  logic              lo_cross;
  logic              lo_fwd;
  logic [PAGE_W-1:0] page_in;
  logic              page_up;
  logic [PAGE_W-1:0] page_out;
  logic              ld_en;
  logic [ADDR_W-1:0] ld_pc;
  logic [CYC_W-1:0]  ld_cycles;

  bnc_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc), .req_taken(req_taken),
    .res_busy(res_valid),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_wrong_page(rd_wrong_page), .rd_data(rd_data),
    .lo_byte(lo_byte), .off_byte(off_byte), .lo_sum(lo_sum), .lo_cross(lo_cross), .lo_fwd(lo_fwd),
    .page_in(page_in), .page_up(page_up), .page_out(page_out),
    .ld_en(ld_en), .ld_pc(ld_pc), .ld_cycles(ld_cycles)
  );

  bnc_lo_add #(.DATA_W(DATA_W)) u_lo (
    .lo_byte(lo_byte), .off_byte(off_byte),
    .lo_sum(lo_sum), .lo_cross(lo_cross), .lo_fwd(lo_fwd)
  );

  bnc_page_fix #(.PAGE_W(PAGE_W)) u_page (
    .page_in(page_in), .page_up(page_up), .page_out(page_out)
  );

  bnc_result_hold #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_pc(ld_pc), .ld_cycles(ld_cycles),
    .res_ready(res_ready), .res_valid(res_valid), .res_pc(res_pc), .res_cycles(res_cycles)
  );
endmodule

// File: rtl/bnc_branch_chk.sv
module bnc_branch_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_pc,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_wrong_page,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_pc,
  input logic [CYC_W-1:0]  res_cycles
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_en);

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rd_en && rd_addr == $past(req_pc));

  assert_offset_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !$past(rd_en) |=> rd_en && rd_addr == $past(rd_addr) + ONE);

  assert_no_retire_on_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrong_page |=> !res_valid);

  assert_page_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrong_page |=> rd_en
      && rd_addr[DATA_W-1:0] == $past(rd_addr[DATA_W-1:0])
      && rd_addr[ADDR_W-1:DATA_W] != $past(rd_addr[ADDR_W-1:DATA_W]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pc) && $stable(res_cycles));

  assert_quiet_while_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !rd_en && !req_ready);

  assert_cycle_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_cycles >= CYC_W'(2) && res_cycles <= CYC_W'(4));
endmodule

bind bnc_branch_seq bnc_branch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(bnc_pkg::CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_wrong_page(rd_wrong_page),
  .res_valid(res_valid), .res_ready(res_ready), .res_pc(res_pc), .res_cycles(res_cycles)
);

// File: tb/test_bnc_branch_seq.sv
`timescale 1ns/1ps
module test_bnc_branch_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_pc = '0;
  logic        req_taken = 1'b0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic        rd_wrong_page;
  logic [7:0]  rd_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_pc;
  logic [2:0]  res_cycles;

  logic [15:0] cur_pc = '0;
  logic [7:0]  cur_off = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: the offset sits right after the opcode, filler elsewhere
  always_comb rd_data = (rd_addr == cur_pc + 16'd1) ? cur_off : 8'hA5;

  bnc_branch_seq i_bnc_branch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_taken(req_taken), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_wrong_page(rd_wrong_page), .rd_data(rd_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_pc(res_pc), .res_cycles(res_cycles)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_branch(input string rq, input logic [15:0] pc0, input logic [7:0] off,
                            input logic tk, input int hold, input bit noise);
    logic [15:0] base, tgt;
    logic        xpg;
    int          exp_n, n;
    logic [15:0] exp_a [5];
    logic        exp_w [5];
    logic [15:0] got_a [8];
    logic        got_w [8];
    base = pc0 + 16'd2;
    tgt  = tk ? base + {{8{off[7]}}, off} : base;
    xpg  = tk && (tgt[15:8] != base[15:8]);
    exp_a[0] = pc0; exp_a[1] = pc0 + 16'd1; exp_a[2] = base;
    exp_a[3] = {base[15:8], tgt[7:0]}; exp_a[4] = tgt;
    for (int i = 0; i < 5; i++) exp_w[i] = 1'b0;
    exp_w[3] = xpg;
    exp_n = !tk ? 3 : (xpg ? 5 : 4);

    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready before request", 32'(req_ready), 1);
    cur_pc = pc0; cur_off = off;
    req_pc = pc0; req_taken = tk; req_valid = 1'b1;
    @(posedge clk); #1;
    if (noise) begin
      req_pc = pc0 ^ 16'h5A5A;
      req_taken = ~tk;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    @(negedge clk);
    while (rd_en === 1'b1 && n < 8) begin
      got_a[n] = rd_addr; got_w[n] = rd_wrong_page; n++;
      @(negedge clk);
    end
    chk(n == exp_n, "R11", "read count", 32'(n), 32'(exp_n));
    for (int i = 0; i < 5; i++) begin
      if (i < n && i < exp_n) begin
        chk(got_a[i] == exp_a[i], (i < 2) ? "R2" : rq, $sformatf("read %0d addr", i),
            32'(got_a[i]), 32'(exp_a[i]));
        chk(got_w[i] == exp_w[i], rq, $sformatf("read %0d wrong-page flag", i),
            32'(got_w[i]), 32'(exp_w[i]));
      end
    end
    chk(res_valid === 1'b1, rq, "result valid", 32'(res_valid), 1);
    chk(res_pc == tgt, rq, "final pc", 32'(res_pc), 32'(tgt));
    chk(res_cycles == 3'(exp_n - 1), rq, "cycle count", 32'(res_cycles), 32'(exp_n - 1));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(res_valid === 1'b1 && res_pc == tgt && res_cycles == 3'(exp_n - 1), "R8",
          "result held", {res_valid, 12'h0, res_cycles, res_pc}, {1'b1, 12'h0, 3'(exp_n - 1), tgt});
      chk(rd_en === 1'b0 && req_ready === 1'b0, noise ? "R9" : "R8", "quiet while held",
          {rd_en, req_ready}, 0);
    end
    res_ready = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1 res_ready = 1'b0;
    @(negedge clk);
    chk(res_valid === 1'b0 && req_ready === 1'b1 && rd_en === 1'b0, noise ? "R9" : "R8",
        "idle after accept", {res_valid, req_ready, rd_en}, 3'b010);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "reset ready", 32'(req_ready), 1);
    chk(res_valid === 1'b0, "R1", "reset result valid", 32'(res_valid), 0);
    chk(rd_en === 1'b0, "R1", "reset read enable", 32'(rd_en), 0);
  endtask

  task automatic t_not_taken;
    run_branch("R3", 16'h2000, 8'h40, 1'b0, 0, 1'b0);
    run_branch("R3", 16'h12FC, 8'h05, 1'b0, 0, 1'b0);
  endtask

  task automatic t_same_page;
    run_branch("R4", 16'h4010, 8'h20, 1'b1, 0, 1'b0);
    run_branch("R4", 16'h4080, 8'hF0, 1'b1, 0, 1'b0);
    run_branch("R4", 16'h6000, 8'h00, 1'b1, 0, 1'b0);
  endtask

  task automatic t_cross_fwd;
    run_branch("R5", 16'h12FC, 8'h05, 1'b1, 0, 1'b0);
  endtask

  task automatic t_cross_back;
    run_branch("R6", 16'h3400, 8'hFB, 1'b1, 0, 1'b0);
  endtask

  task automatic t_extremes;
    run_branch("R7", 16'h507E, 8'h7F, 1'b1, 0, 1'b0);
    run_branch("R7", 16'h507E, 8'h80, 1'b1, 0, 1'b0);
    run_branch("R7", 16'h507F, 8'h7F, 1'b1, 0, 1'b0);
    run_branch("R7", 16'h507D, 8'h80, 1'b1, 0, 1'b0);
  endtask

  task automatic t_wrap;
    run_branch("R10", 16'hFFFC, 8'h05, 1'b1, 0, 1'b0);
    run_branch("R10", 16'h0000, 8'hFB, 1'b1, 0, 1'b0);
    run_branch("R10", 16'hFFFF, 8'h10, 1'b1, 0, 1'b0);
  endtask

  task automatic t_backpressure;
    run_branch("R8", 16'h7AFD, 8'h09, 1'b1, 4, 1'b0);
    run_branch("R9", 16'h1234, 8'h22, 1'b1, 3, 1'b1);
    run_branch("R9", 16'h0F00, 8'hC0, 1'b0, 2, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_not_taken();
    t_same_page();
    t_cross_fwd();
    t_cross_back();
    t_extremes();
    t_wrap();
    t_backpressure();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule